// File: doc/BRIEF.md
# Synchronous Late-Write Burst SRAM

This block is a single-port synchronous memory of 36-bit words. Each word is split into four 9-bit lanes, and each lane holds eight data bits and one parity bit. On a rising edge with the load input active, the block starts a new cycle. That cycle is a read burst, a write burst or a deselect, and the choice depends on the three chip selects and the read select. On edges with the advance input active, the current burst steps to its next address inside an aligned group of four words. The step order is either linear or interleaved.

Reads flow through with no output register: the word at the address loaded on an edge appears on `dout` during the cycle that follows that edge. Writes are late: the data for an address loaded on edge N is taken from `din` on the next active edge. The byte-lane mask captured with the address decides which lanes are written. A pending-write register holds that address and mask until the data arrives. Because the data is committed on the same edge that loads the next access, a read of the same word one cycle later already sees the merged lanes.

A stall input turns an edge into a no-op. A sleep input switches the outputs off at once and ignores every other input while the memory contents are kept. The output drive enable is asynchronous.

Top module: `lwb_sram`

States of the cycle controller:
- `ST_IDLE`: deselected.
- `ST_RD_FIRST` and `ST_RD_NEXT`: read burst, at the first beat or a later beat.
- `ST_WR_FIRST` and `ST_WR_NEXT`: write burst, at the first beat or a later beat.

Transitions, all on an active edge:
- A load with all selects true goes to `ST_RD_FIRST` when `is_read` is 1, or to `ST_WR_FIRST` when it is 0.
- A load with any select false goes to `ST_IDLE`.
- An advance moves either read state to `ST_RD_NEXT` and either write state to `ST_WR_NEXT`, and leaves `ST_IDLE` unchanged.
- A sleep edge or a recovery edge forces `ST_IDLE`.

## Requirements
- R1: While `rst_n` is low, each edge puts the block in the deselected state with no pending write, and `dout_oe` is 0 in the cycles after such an edge.
- R2: On an active edge with `burst_next`=0, `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0 and `is_read`=1, a read burst starts. In the following cycle `dout` shows the word at `addr`, and `dout_oe` is 1 when `drive_en_n` is 0.
- R3: A load edge with any other select combination deselects the block. `dout_oe` stays 0, and no memory word changes because of that load.
- R4: After a write load or write advance, the next active edge stores `din`. A 0 on `lane_wr_n[i]` writes bits [9i+8:9i] (lane 0 is bits 8:0), and a 1 leaves that lane unchanged. With all four at 1 nothing is written, but the burst still advances.
- R5: On an edge with `burst_next`=1, the selects, `is_read` and `addr` are ignored. A read or write burst continues, and a deselected block stays deselected.
- R6: The burst keeps the upper address bits of the loaded address. Its two low bits on beat k (k=0..3, wrapping after 3) are start+k mod 4 when `linear_order`=1, and start XOR k when `linear_order`=0.
- R7: An edge with `stall`=1 changes nothing: state, burst address and pending write all hold, and the write data is taken on the next non-stalled edge.
- R8: While `sleep` is 1, `dout_oe` is 0 at once, every edge is ignored and no memory word changes. The first two edges after `sleep` falls are also ignored, and they leave the block deselected.
- R9: `drive_en_n`=1 forces `dout_oe` to 0 at once. During write and deselect cycles `dout_oe` is 0 whatever `drive_en_n` is. `dout` is 0 whenever `dout_oe` is 0.
- R10: A read loaded on the edge that commits a write to the same word returns the merged word in the following cycle.
- R11: A read burst cannot turn into a write burst, or a write burst into a read burst, except by a load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW ($clog2(DEPTH)) | Word address, used on load edges |
| sel_a_n | input | 1 | Chip select, active low, used on load edges |
| sel_b | input | 1 | Chip select, active high, used on load edges |
| sel_c_n | input | 1 | Chip select, active low, used on load edges |
| burst_next | input | 1 | 0 loads a new access, 1 advances the burst |
| is_read | input | 1 | 1 selects a read burst and 0 a write burst, used on load edges |
| lane_wr_n | input | LANES | Active-low write enable for each byte lane, sampled with the address |
| stall | input | 1 | 1 makes the edge a no-op |
| drive_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous low-power hold |
| linear_order | input | 1 | 1 selects the linear burst order and 0 the interleaved order (static) |
| din | input | LANES*LANE_W | Write data, one cycle after its address |
| dout | output | LANES*LANE_W | Read data, flowing through from the array |
| dout_oe | output | 1 | Output valid and drive enable |

## Verification
A directed linear write burst that starts mid-group, and the reads that follow it, tell the two burst orders apart and show the wrap. Partial lane masks and an all-ones abort mask are each followed by an immediate read of the same word, which shows the late-write merge and that an aborted burst still advances. During the advance edges the selects and the read select are driven at random, which exposes any dependence on them. Stalls, sleep with its two recovery edges, and toggling of the drive enable are placed in the middle of bursts. A long stream from `$urandom` with a fixed seed then mixes loads, advances, deselects, stalls and sleeps against an array model in the bench, and every cycle compares the drive enable and the data.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD_NEXT,
        ST_WR_FIRST,
        ST_WR_NEXT
    } cyc_state_t;

    // low two address bits for beat number 'beat' of a burst starting at 'start'
    function automatic logic [1:0] beat_offset(
        input logic [1:0] start,
        input logic [1:0] beat,
        input logic       linear
    );
        logic [1:0] sum;
        sum = start + beat;
        return linear ? sum : (start ^ beat);
    endfunction

endpackage

// File: rtl/lwb_ctrl.sv
module lwb_ctrl
    import lwb_pkg::*;
#(
    parameter int WAKE_EDGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       burst_next,
    input  logic       chip_sel,
    input  logic       is_read,
    input  logic       stall,
    input  logic       sleep,
    output cyc_state_t st,
    output logic       nap,
    output logic       adv_edge,
    output logic       load_edge,
    output logic       step_edge,
    output logic       wr_capture,
    output logic       rd_active
);

    localparam int WW = $clog2(WAKE_EDGES + 1);

    cyc_state_t      st_q;
    cyc_state_t      st_nxt;
    cyc_state_t      load_kind;
    logic [WW-1:0]   wake_q;

    // recovery counter: reloaded while asleep, counts down afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q <= '0;
        end else if (sleep) begin
            wake_q <= WW'(WAKE_EDGES);
        end else if (wake_q != '0) begin
            wake_q <= wake_q - 1'b1;
        end
    end

    assign nap      = sleep | (wake_q != '0);
    assign adv_edge = ~nap & ~stall;

    // next-state logic
    always_comb begin
        if (!chip_sel) begin
            load_kind = ST_IDLE;
        end else if (is_read) begin
            load_kind = ST_RD_FIRST;
        end else begin
            load_kind = ST_WR_FIRST;
        end
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (!burst_next) st_nxt = load_kind;
            end
            ST_RD_FIRST, ST_RD_NEXT: begin
                st_nxt = burst_next ? ST_RD_NEXT : load_kind;
            end
            ST_WR_FIRST, ST_WR_NEXT: begin
                st_nxt = burst_next ? ST_WR_NEXT : load_kind;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else if (nap) begin
            st_q <= ST_IDLE;
        end else if (adv_edge) begin
            st_q <= st_nxt;
        end
    end

    // outputs
    always_comb begin
        rd_active  = 1'b0;
        wr_capture = 1'b0;
        unique case (st_q)
            ST_RD_FIRST, ST_RD_NEXT: rd_active = 1'b1;
            default: rd_active = 1'b0;
        endcase
        unique case (st_nxt)
            ST_WR_FIRST, ST_WR_NEXT: wr_capture = adv_edge;
            default: wr_capture = 1'b0;
        endcase
        load_edge = adv_edge & ~burst_next;
        step_edge = adv_edge & burst_next & (st_q != ST_IDLE);
    end

    assign st = st_q;

endmodule

// File: rtl/lwb_burst_ctr.sv
module lwb_burst_ctr
    import lwb_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          linear,
    input  logic          load_edge,
    input  logic          step_edge,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);

    logic [AW-1:0] base_q;
    logic [1:0]    beat_q;
    logic [1:0]    beat_inc;

    assign beat_inc = beat_q + 2'd1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (load_edge) begin
            base_q <= addr_in;
            beat_q <= '0;
        end else if (step_edge) begin
            beat_q <= beat_inc;
        end
    end

    assign cur_addr = {base_q[AW-1:2], beat_offset(base_q[1:0], beat_q, linear)};

    always_comb begin
        if (load_edge) begin
            nxt_addr = addr_in;
        end else if (step_edge) begin
            nxt_addr = {base_q[AW-1:2], beat_offset(base_q[1:0], beat_inc, linear)};
        end else begin
            nxt_addr = cur_addr;
        end
    end

endmodule

// File: rtl/lwb_wrbuf.sv
module lwb_wrbuf #(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nap,
    input  logic             adv_edge,
    input  logic             capture,
    input  logic [AW-1:0]    nxt_addr,
    input  logic [LANES-1:0] lane_wr_n,
    output logic             commit,
    output logic [AW-1:0]    pend_addr,
    output logic [LANES-1:0] pend_mask
);

    logic valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            pend_addr <= '0;
            pend_mask <= '0;
        end else if (nap) begin
            valid_q   <= 1'b0;
        end else if (adv_edge) begin
            valid_q   <= capture;
            pend_addr <= nxt_addr;
            pend_mask <= ~lane_wr_n;
        end
    end

    // data for the held address arrives on the next active edge
    assign commit = valid_q & adv_edge;

endmodule

// File: rtl/lwb_array.sv
module lwb_array #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES-1:0]        wmask,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g]) begin
                lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/lwb_sram.sv
module lwb_sram
    import lwb_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int LANES      = 4,
    parameter int LANE_W     = 9,
    parameter int WAKE_EDGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(DEPTH)-1:0]     addr,
    input  logic                         sel_a_n,
    input  logic                         sel_b,
    input  logic                         sel_c_n,
    input  logic                         burst_next,
    input  logic                         is_read,
    input  logic [LANES-1:0]             lane_wr_n,
    input  logic                         stall,
    input  logic                         drive_en_n,
    input  logic                         sleep,
    input  logic                         linear_order,
    input  logic [LANES*LANE_W-1:0]      din,
    output logic [LANES*LANE_W-1:0]      dout,
    output logic                         dout_oe
);

    localparam int AW     = $clog2(DEPTH);
    localparam int WORD_W = LANES * LANE_W;

    cyc_state_t        state_w;
    logic              chip_sel_w;
    logic              nap_w;
    logic              adv_edge_w;
    logic              load_edge_w;
    logic              step_edge_w;
    logic              wr_capture_w;
    logic              rd_active_w;
    logic              commit_w;
    logic [AW-1:0]     cur_addr_w;
    logic [AW-1:0]     nxt_addr_w;
    logic [AW-1:0]     pend_addr_w;
    logic [LANES-1:0]  pend_mask_w;
    logic [WORD_W-1:0] rdata_w;

    assign chip_sel_w = ~sel_a_n & sel_b & ~sel_c_n;

    lwb_ctrl #(.WAKE_EDGES(WAKE_EDGES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_next (burst_next),
        .chip_sel   (chip_sel_w),
        .is_read    (is_read),
        .stall      (stall),
        .sleep      (sleep),
        .st         (state_w),
        .nap        (nap_w),
        .adv_edge   (adv_edge_w),
        .load_edge  (load_edge_w),
        .step_edge  (step_edge_w),
        .wr_capture (wr_capture_w),
        .rd_active  (rd_active_w)
    );

    lwb_burst_ctr #(.AW(AW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .linear    (linear_order),
        .load_edge (load_edge_w),
        .step_edge (step_edge_w),
        .addr_in   (addr),
        .cur_addr  (cur_addr_w),
        .nxt_addr  (nxt_addr_w)
    );

    lwb_wrbuf #(.AW(AW), .LANES(LANES)) u_wrbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .nap       (nap_w),
        .adv_edge  (adv_edge_w),
        .capture   (wr_capture_w),
        .nxt_addr  (nxt_addr_w),
        .lane_wr_n (lane_wr_n),
        .commit    (commit_w),
        .pend_addr (pend_addr_w),
        .pend_mask (pend_mask_w)
    );

    lwb_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_array (
        .clk   (clk),
        .we    (commit_w),
        .waddr (pend_addr_w),
        .wmask (pend_mask_w),
        .wdata (din),
        .raddr (cur_addr_w),
        .rdata (rdata_w)
    );

    assign dout_oe = rd_active_w & ~drive_en_n & ~nap_w;
    assign dout    = dout_oe ? rdata_w : '0;

endmodule

// File: rtl/lwb_sram_chk.sv
module lwb_sram_chk
    import lwb_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          burst_next,
    input logic          is_read,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          sel_c_n,
    input logic          stall,
    input logic          sleep,
    input logic          drive_en_n,
    input logic          dout_oe,
    input cyc_state_t    state_w,
    input logic          nap_w,
    input logic          adv_edge_w,
    input logic          commit_w,
    input logic [AW-1:0] cur_addr_w
);

    logic sel_ok;
    assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;

    a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_edge_w && !burst_next && sel_ok && is_read) |=> (dout_oe == (!drive_en_n && !sleep)));

    a_r3_desel_load: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_edge_w && !burst_next && !sel_ok) |=> (state_w == ST_IDLE && !dout_oe));

    a_r4_commit_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        commit_w |-> (state_w == ST_WR_FIRST || state_w == ST_WR_NEXT));

    a_r5_write_keeps_type: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_edge_w && burst_next && (state_w == ST_WR_FIRST || state_w == ST_WR_NEXT))
        |=> (state_w == ST_WR_NEXT));

    a_r11_read_keeps_type: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_edge_w && burst_next && (state_w == ST_RD_FIRST || state_w == ST_RD_NEXT))
        |=> (state_w == ST_RD_NEXT));

    a_r6_upper_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_edge_w && burst_next && state_w != ST_IDLE)
        |=> (cur_addr_w[AW-1:2] == $past(cur_addr_w[AW-1:2])));

    a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !nap_w) |=> ($stable(state_w) && $stable(cur_addr_w)));

    a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!commit_w && !dout_oe));

    a_r9_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_n |-> !dout_oe);

endmodule

bind lwb_sram lwb_sram_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_next (burst_next),
    .is_read    (is_read),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .stall      (stall),
    .sleep      (sleep),
    .drive_en_n (drive_en_n),
    .dout_oe    (dout_oe),
    .state_w    (state_w),
    .nap_w      (nap_w),
    .adv_edge_w (adv_edge_w),
    .commit_w   (commit_w),
    .cur_addr_w (cur_addr_w)
);

// File: tb/sim_lwb_sram.sv
module sim_lwb_sram;

    localparam int DEPTH  = 64;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WW     = LANES * LANE_W;
    localparam int AW     = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          burst_next = 1'b0;
    logic          is_read = 1'b1;
    logic [LANES-1:0] lane_wr_n = '1;
    logic          stall = 1'b0;
    logic          drive_en_n = 1'b0;
    logic          sleep = 1'b0;
    logic          linear_order = 1'b1;
    logic [WW-1:0] din = '0;
    logic [WW-1:0] dout;
    logic          dout_oe;

    lwb_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .burst_next(burst_next), .is_read(is_read),
        .lane_wr_n(lane_wr_n), .stall(stall), .drive_en_n(drive_en_n),
        .sleep(sleep), .linear_order(linear_order), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    always #10 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // reference model
    logic [WW-1:0]    ref_mem [DEPTH];
    int               m_st = 0;        // 0 deselect, 1 read, 2 write
    logic [AW-1:0]    m_base = '0;
    logic [1:0]       m_cnt = '0;
    bit               p_valid = 1'b0;
    logic [AW-1:0]    p_addr = '0;
    logic [LANES-1:0] p_mask = '0;
    int               wake = 0;

    localparam logic [WW-1:0] W0 = 36'h1A2B3C4D5;
    localparam logic [WW-1:0] W1 = 36'h2468ACE13;
    localparam logic [WW-1:0] W2 = 36'h3579BDF02;
    localparam logic [WW-1:0] W3 = 36'h4C0FFEE01;
    localparam logic [WW-1:0] KV = 36'h5DEADBEEF;
    localparam logic [WW-1:0] ONES = '1;
    localparam logic [WW-1:0] M02  = 36'h007FC01FF; // lanes 0 and 2

    function automatic logic [AW-1:0] cur_word();
        logic [1:0] off;
        off = linear_order ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
        return {m_base[AW-1:2], off};
    endfunction

    function automatic bit sel_true();
        return !sel_a_n && sel_b && !sel_c_n;
    endfunction

    task automatic model_edge();
        if (!rst_n) begin
            m_st = 0; m_base = '0; m_cnt = '0; p_valid = 1'b0; wake = 0;
        end else if (sleep || wake != 0) begin
            wake = sleep ? 2 : wake - 1;
            m_st = 0; p_valid = 1'b0;
        end else if (!stall) begin
            if (p_valid)
                for (int l = 0; l < LANES; l++)
                    if (p_mask[l]) ref_mem[p_addr][l*LANE_W +: LANE_W] = din[l*LANE_W +: LANE_W];
            if (!burst_next) begin
                m_base = addr; m_cnt = '0;
                m_st = sel_true() ? (is_read ? 1 : 2) : 0;
            end else if (m_st != 0) begin
                m_cnt = m_cnt + 2'd1;
            end
            if (m_st == 2) begin
                p_valid = 1'b1; p_addr = cur_word(); p_mask = ~lane_wr_n;
            end else begin
                p_valid = 1'b0;
            end
        end
    endtask

    task automatic chk(input string t, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", t, got, exp);
        end
    endtask

    task automatic check_out();
        bit            e_oe;
        logic [WW-1:0] e_d;
        e_oe = (m_st == 1) && !drive_en_n && !sleep && (wake == 0);
        e_d  = e_oe ? ref_mem[cur_word()] : '0;
        chk(tag, {27'd0, dout_oe, dout}, {27'd0, e_oe, e_d});
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_out();
    endtask

    task automatic do_load(input int a, input bit rd, input logic [WW-1:0] d,
                           input logic [3:0] bw, input logic [2:0] sv = 3'b010);
        addr = AW'(a); burst_next = 1'b0; is_read = rd; din = d; lane_wr_n = bw;
        {sel_a_n, sel_b, sel_c_n} = sv;
        tick();
    endtask

    task automatic do_adv(input logic [WW-1:0] d, input logic [3:0] bw);
        burst_next = 1'b1; din = d; lane_wr_n = bw;
        addr = AW'($urandom);
        {sel_a_n, sel_b, sel_c_n} = 3'($urandom);
        is_read = 1'($urandom);
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        tag = "R1";
        tick(); tick();
        chk("R1", {63'd0, dout_oe}, 64'd0);
        rst_n = 1'b1;

        // prefill every word with single-beat writes
        tag = "R4";
        for (int a = 0; a < DEPTH; a++)
            do_load(a, 1'b0, 36'({$urandom, $urandom}), 4'h0);
        do_load(0, 1'b1, 36'({$urandom, $urandom}), 4'h0, 3'b110);

        // R4/R6: linear write burst from offset 2, then read back
        tag = "R6"; linear_order = 1'b1;
        do_load(6, 1'b0, '0, 4'h0);
        do_adv(W0, 4'h0);
        do_adv(W1, 4'h0);
        do_adv(W2, 4'h0);
        do_load(6, 1'b1, W3, 4'h0);
        chk("R6 linear beat0", dout, W0);
        do_adv('0, 4'hF); chk("R6 linear beat1", dout, W1);
        do_adv('0, 4'hF); chk("R6 linear beat2", dout, W2);
        do_adv('0, 4'hF); chk("R6 linear beat3", dout, W3);
        do_adv('0, 4'hF); chk("R6 linear wrap", dout, W0);

        // R6: interleaved order from offset 1 -> 1,0,3,2
        linear_order = 1'b0;
        do_load(5, 1'b1, '0, 4'hF);
        chk("R6 interleave beat0", dout, W3);
        do_adv('0, 4'hF); chk("R6 interleave beat1", dout, W2);
        do_adv('0, 4'hF); chk("R6 interleave beat2", dout, W1);
        do_adv('0, 4'hF); chk("R6 interleave beat3", dout, W0);

        // R4/R10: lanes 0 and 2 only, read back on the commit edge
        tag = "R10"; linear_order = 1'b1;
        do_load(6, 1'b0, '0, 4'b1010);
        do_load(6, 1'b1, ONES, 4'hF);
        chk("R10 merged lanes", dout, (W0 & ~M02) | M02);

        // R4: write abort still advances
        tag = "R4";
        do_load(7, 1'b0, '0, 4'hF);
        do_adv(ONES, 4'hF);
        do_load(7, 1'b1, ONES, 4'h0);
        chk("R4 abort keeps word", dout, W1);
        do_adv('0, 4'hF); chk("R4 aborted beat keeps word", dout, W2);

        // R7: stall holds a pending write and a read
        tag = "R7";
        do_load(16, 1'b0, '0, 4'h0);
        stall = 1'b1;
        for (int i = 0; i < 3; i++) begin
            addr = AW'($urandom); burst_next = 1'($urandom); din = 36'({$urandom, $urandom});
            tick();
            chk("R7 stalled write no drive", {63'd0, dout_oe}, 64'd0);
        end
        stall = 1'b0;
        do_load(16, 1'b1, KV, 4'h0);
        chk("R7 data taken after stall", dout, KV);
        stall = 1'b1;
        for (int i = 0; i < 3; i++) begin
            addr = AW'($urandom); burst_next = 1'($urandom); is_read = 1'($urandom);
            tick();
            chk("R7 stalled read holds", {27'd0, dout_oe, dout}, {27'd0, 1'b1, KV});
        end
        stall = 1'b0;

        // R8: sleep
        tag = "R8";
        sleep = 1'b1; #1;
        chk("R8 outputs off at once", {63'd0, dout_oe}, 64'd0);
        do_load(16, 1'b0, ONES, 4'h0);
        do_load(16, 1'b0, ONES, 4'h0);
        sleep = 1'b0;
        do_load(16, 1'b1, ONES, 4'h0);
        chk("R8 recovery edge 1 ignored", {63'd0, dout_oe}, 64'd0);
        do_load(16, 1'b1, ONES, 4'h0);
        chk("R8 recovery edge 2 ignored", {63'd0, dout_oe}, 64'd0);
        do_load(16, 1'b1, ONES, 4'h0);
        chk("R8 contents retained", {27'd0, dout_oe, dout}, {27'd0, 1'b1, KV});

        // R9: drive enable
        tag = "R9";
        drive_en_n = 1'b1; #1;
        chk("R9 drive off", {63'd0, dout_oe}, 64'd0);
        drive_en_n = 1'b0; #1;
        chk("R9 drive back", {27'd0, dout_oe, dout}, {27'd0, 1'b1, KV});
        do_load(20, 1'b0, '0, 4'hF);
        chk("R9 off in write", {63'd0, dout_oe}, 64'd0);

        // R3: deselecting loads
        tag = "R3";
        do_load(16, 1'b0, '0, 4'h0, 3'b000);
        chk("R3 sel_b low deselects", {63'd0, dout_oe}, 64'd0);
        do_load(16, 1'b1, ONES, 4'h0, 3'b011);
        chk("R3 sel_c_n high deselects", {63'd0, dout_oe}, 64'd0);
        tag = "R5";
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0; is_read = 1'b1; burst_next = 1'b1;
        tick();
        chk("R5 advance keeps deselect", {63'd0, dout_oe}, 64'd0);
        do_load(16, 1'b1, ONES, 4'h0);
        chk("R3 word untouched", dout, KV);

        // R11: read burst ignores write select on advance
        tag = "R11";
        for (int i = 0; i < 3; i++) begin
            burst_next = 1'b1; is_read = 1'b0; lane_wr_n = 4'h0; din = ONES;
            {sel_a_n, sel_b, sel_c_n} = 3'($urandom);
            tick();
            chk("R11 stays read", {63'd0, dout_oe}, 64'd1);
        end
        do_load(16, 1'b1, '0, 4'hF);
        chk("R11 no write happened", dout, KV);

        // mixed random traffic
        tag = "R5";
        begin
            int sleep_left = 0;
            for (int c = 0; c < 4000; c++) begin
                int r;
                r = int'($urandom % 100);
                if (c % 500 == 0) linear_order = 1'($urandom);
                if (sleep_left > 0) begin
                    sleep_left--; sleep = (sleep_left != 0);
                end else if (r < 2) begin
                    sleep = 1'b1; sleep_left = 1 + int'($urandom % 3);
                end else begin
                    sleep = 1'b0;
                end
                stall      = ($urandom % 10) == 0;
                drive_en_n = ($urandom % 10) == 0;
                burst_next = 1'($urandom);
                is_read    = 1'($urandom);
                {sel_a_n, sel_b, sel_c_n} = (($urandom % 4) == 0) ? 3'($urandom) : 3'b010;
                lane_wr_n  = 4'($urandom);
                addr       = AW'($urandom);
                din        = 36'({$urandom, $urandom});
                tick();
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule